// File: doc/BRIEF.md
# Two-Stage Strobe Capture Latch

This block accepts a 12-bit word from a writer that runs without a shared clock. The writer marks each word with a strobe pulse. The block hands the word to an encoder holding register, and that hand-off is timed by the falling edge of a slower byte clock. The block has two storage slots. The rear slot holds the word that goes to the encoder next. The front slot holds one more word while the rear slot is full. When the rear slot is free, a strobe writes straight into it. Otherwise the strobe writes into the front slot. A later strobe in the same byte period writes over the front slot.

Both the strobe and the byte clock are asynchronous to the system clock `clk_i`. Each one passes through its own two-flop synchronizer with an edge detector. A strobe event is the detected rising edge of the strobe. A promotion event is the detected falling edge of the byte clock. The writer receives two signals back:
- a level acknowledge, which is high when its last word has reached the rear slot;
- a busy flag, which is high while a word waits in the front slot.

Top module: `strobe_latch`

## Requirements
- R1: After reset, `ack_o`, `busy_o` and `enc_word_o` are 0, and `enc_load_o` stays low until the first promotion event.
- R2: A rising edge on `strobe_i` takes effect on the third rising edge of `clk_i` after the edge that first samples it. A strobe held high loads exactly one word.
- R3: When a strobe event finds both slots empty, the word goes into the rear slot and `ack_o` becomes 1 on the same update. `busy_o` stays 0.
- R4: On a promotion event with the rear slot full, `enc_word_o` takes the rear word, and `enc_load_o` pulses high for one cycle. On a promotion event with the rear slot empty, there is no pulse and `enc_word_o` keeps its value.
- R5: When a strobe event finds the rear slot full, the word goes into the front slot. `busy_o` becomes 1 and `ack_o` becomes 0.
- R6: On a promotion event with the front slot full, the front word moves into the rear slot. `busy_o` returns to 0 and `ack_o` becomes 1.
- R7: A strobe event while the front slot is full replaces the front word. Only the last such word reaches the encoder.
- R8: When a strobe event and a promotion event fall in the same cycle, the promotion is applied first and the strobe is then placed against the resulting slot state.
- R9: `ack_o` is a level. It changes only on a strobe event or on a promotion that moves a front word into the rear slot.
- R10: `word_i` is sampled on the update edge of R2 and must be stable from the strobe rise until then. Bit i of `word_i` appears unchanged as bit i of `enc_word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_clk_i | input | 1 | Byte clock; its falling edge promotes the slots |
| strobe_i | input | 1 | Asynchronous write strobe; its rising edge captures `word_i` |
| word_i | input | 12 | Word to capture (data and command bits) |
| enc_word_o | output | 12 | Encoder holding register |
| enc_load_o | output | 1 | One-cycle pulse when `enc_word_o` is loaded |
| ack_o | output | 1 | Level acknowledge: the last word has reached the rear slot |
| busy_o | output | 1 | A word is waiting in the front slot |

## Verification
The bench sends strobes into an empty latch, a half-full latch and a full latch, and checks the four cases below:
- **Bypass into an empty latch.** A design that always went through the front slot would raise busy and delay the acknowledge.
- **Overwrite of a full front slot.** A design that protected the front slot would deliver the older word to the encoder.
- **Strobe and promotion in the same cycle.** Applying the two in the wrong order would drop a word or send it the wrong way.
- **Strobe held high.** A level-sensitive capture would load the word several times.

Promotions with the rear slot empty check that the encoder register neither reloads nor pulses, and that the acknowledge level stays where it was.

// File: rtl/strobe_latch_pkg.sv
package strobe_latch_pkg;
  parameter int unsigned DEF_WORD_W      = 12;
  parameter int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_BYPASS = 2'd1,
    ACT_QUEUE  = 2'd2
  } stb_act_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int unsigned STAGES = 2,
  parameter bit          FALL   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic evt_o
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], async_i};
  end

  generate
    if (FALL) begin : g_fall
      assign evt_o = sh_q[LAST] & ~sh_q[LAST-1];
    end else begin : g_rise
      assign evt_o = sh_q[LAST-1] & ~sh_q[LAST];
    end
  endgenerate
endmodule

// File: rtl/latch_core.sv
module latch_core
  import strobe_latch_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_evt_i,
  input  logic              prom_evt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              rear_v_o,
  output logic [WORD_W-1:0] rear_d_o,
  output logic              front_v_o,
  output logic [WORD_W-1:0] front_d_o,
  output logic              ack_o,
  output logic              take_o,
  output logic [WORD_W-1:0] take_d_o
);
  logic              rear_v_q, front_v_q, ack_q;
  logic [WORD_W-1:0] rear_d_q, front_d_q;
  logic              rear_v_p, front_v_p;
  logic [WORD_W-1:0] rear_d_p;
  logic              rear_v_d, front_v_d, ack_d;
  logic [WORD_W-1:0] rear_d_d, front_d_d;
  stb_act_e          act;

  // stage 1: promotion
  always_comb begin
    rear_v_p  = rear_v_q;
    rear_d_p  = rear_d_q;
    front_v_p = front_v_q;
    if (prom_evt_i) begin
      rear_v_p  = front_v_q;
      rear_d_p  = front_d_q;
      front_v_p = 1'b0;
    end
  end

  // stage 2: strobe placed against post-promotion state
  always_comb begin
    act = ACT_NONE;
    if (stb_evt_i) act = rear_v_p ? ACT_QUEUE : ACT_BYPASS;
  end

  always_comb begin
    rear_v_d  = rear_v_p;
    rear_d_d  = rear_d_p;
    front_v_d = front_v_p;
    front_d_d = front_d_q;
    ack_d     = ack_q;
    if (prom_evt_i && front_v_q) ack_d = 1'b1;
    unique case (act)
      ACT_BYPASS: begin
        rear_v_d = 1'b1;
        rear_d_d = word_i;
        ack_d    = 1'b1;
      end
      ACT_QUEUE: begin
        front_v_d = 1'b1;
        front_d_d = word_i;
        ack_d     = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rear_v_q  <= 1'b0;
      rear_d_q  <= '0;
      front_v_q <= 1'b0;
      front_d_q <= '0;
      ack_q     <= 1'b0;
    end else begin
      rear_v_q  <= rear_v_d;
      rear_d_q  <= rear_d_d;
      front_v_q <= front_v_d;
      front_d_q <= front_d_d;
      ack_q     <= ack_d;
    end
  end

  assign rear_v_o  = rear_v_q;
  assign rear_d_o  = rear_d_q;
  assign front_v_o = front_v_q;
  assign front_d_o = front_d_q;
  assign ack_o     = ack_q;
  assign take_o    = prom_evt_i & rear_v_q;
  assign take_d_o  = rear_d_q;
endmodule

// File: rtl/enc_hold_reg.sv
module enc_hold_reg #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [WORD_W-1:0] take_d_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= take_i;
      if (take_i) word_o <= take_d_i;
    end
  end
endmodule

// File: rtl/strobe_latch.sv
module strobe_latch
  import strobe_latch_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_clk_i,
  input  logic              strobe_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] enc_word_o,
  output logic              enc_load_o,
  output logic              ack_o,
  output logic              busy_o
);
  logic              stb_evt, prom_evt;
  logic              rear_v, front_v, take;
  logic [WORD_W-1:0] rear_d, front_d, take_d;

  sync_edge #(.STAGES(SYNC_STAGES), .FALL(1'b0)) u_stb_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(strobe_i),
    .evt_o  (stb_evt)
  );

  sync_edge #(.STAGES(SYNC_STAGES), .FALL(1'b1)) u_byte_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(byte_clk_i),
    .evt_o  (prom_evt)
  );

  latch_core #(.WORD_W(WORD_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_evt_i (stb_evt),
    .prom_evt_i(prom_evt),
    .word_i    (word_i),
    .rear_v_o  (rear_v),
    .rear_d_o  (rear_d),
    .front_v_o (front_v),
    .front_d_o (front_d),
    .ack_o     (ack_o),
    .take_o    (take),
    .take_d_o  (take_d)
  );

  enc_hold_reg #(.WORD_W(WORD_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .take_d_i(take_d),
    .word_o  (enc_word_o),
    .load_o  (enc_load_o)
  );

  assign busy_o = front_v;
endmodule

// File: rtl/strobe_latch_chk.sv
module strobe_latch_chk #(
  parameter int unsigned WORD_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_evt,
  input logic              prom_evt,
  input logic [WORD_W-1:0] word_i,
  input logic              rear_v,
  input logic [WORD_W-1:0] rear_d,
  input logic              front_v,
  input logic [WORD_W-1:0] front_d,
  input logic [WORD_W-1:0] enc_word_o,
  input logic              enc_load_o,
  input logic              ack_o,
  input logic              busy_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> !enc_load_o && !ack_o && !busy_o); // R1

  AST_BYPASS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_evt && !rear_v && !front_v |=> rear_v && ack_o && !busy_o && rear_d == $past(word_i)); // R3

  AST_PROMOTE_ENC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_evt && rear_v |=> enc_load_o && enc_word_o == $past(rear_d)); // R4

  AST_NO_IDLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prom_evt && rear_v) |=> !enc_load_o && $stable(enc_word_o)); // R4

  AST_QUEUE_FRONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_evt && rear_v && !prom_evt |=> busy_o && !ack_o && front_d == $past(word_i)); // R5

  AST_FRONT_TO_REAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_evt && front_v && !stb_evt |=> ack_o && !busy_o && rear_d == $past(front_d)); // R6

  AST_ACK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_evt && !prom_evt |=> $stable(ack_o)); // R9
endmodule

bind strobe_latch strobe_latch_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stb_evt   (stb_evt),
  .prom_evt  (prom_evt),
  .word_i    (word_i),
  .rear_v    (rear_v),
  .rear_d    (rear_d),
  .front_v   (front_v),
  .front_d   (front_d),
  .enc_word_o(enc_word_o),
  .enc_load_o(enc_load_o),
  .ack_o     (ack_o),
  .busy_o    (busy_o)
);

// File: tb/tb_strobe_latch.sv
module tb_strobe_latch;
  localparam int W = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         byte_clk_i = 1'b1;
  logic         strobe_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic [W-1:0] enc_word_o;
  logic         enc_load_o, ack_o, busy_o;

  int n_chk = 0, n_fail = 0, load_cnt = 0;
  bit done = 1'b0;

  // reference model
  bit           m_rv, m_fv, m_ack;
  logic [W-1:0] m_rd, m_fd, m_enc;
  int           m_loads;

  always #5 clk_i = ~clk_i;

  strobe_latch dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_clk_i(byte_clk_i), .strobe_i(strobe_i),
    .word_i(word_i), .enc_word_o(enc_word_o), .enc_load_o(enc_load_o),
    .ack_o(ack_o), .busy_o(busy_o)
  );

  always @(posedge clk_i) if (rst_ni && enc_load_o) load_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit p, input bit s, input logic [W-1:0] w);
    if (p) begin
      if (m_rv) begin m_enc = m_rd; m_loads++; end
      if (m_fv) m_ack = 1'b1;
      m_rv = m_fv; m_rd = m_fd; m_fv = 1'b0;
    end
    if (s) begin
      if (!m_rv) begin m_rv = 1'b1; m_rd = w; m_ack = 1'b1; end
      else begin m_fv = 1'b1; m_fd = w; m_ack = 1'b0; end
    end
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R4 enc_word"}, int'(enc_word_o), int'(m_enc));
    chk({tag, " R4 load count"}, load_cnt, m_loads);
    chk({tag, " R5 busy"}, int'(busy_o), int'(m_fv));
    chk({tag, " R9 ack"}, int'(ack_o), int'(m_ack));
  endtask

  // p: byte clock falling edge, s: strobe rise; both driven on the same negedge
  task automatic op(input bit p, input bit s, input logic [W-1:0] w, input int hold, input string tag);
    @(negedge clk_i);
    if (s) begin word_i = w; strobe_i = 1'b1; end
    if (p) byte_clk_i = 1'b0;
    repeat (hold) @(negedge clk_i);
    model(p, s, w);
    check_all(tag);
    strobe_i = 1'b0;
    byte_clk_i = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_rv = 0; m_fv = 0; m_ack = 0; m_rd = '0; m_fd = '0; m_enc = '0; m_loads = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 ack", int'(ack_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 enc_word", int'(enc_word_o), 0);
    chk("R1 load", int'(enc_load_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2 timing: update on third rising edge after first sample
    @(negedge clk_i);
    word_i = 12'hA5C; strobe_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R2 no early ack", int'(ack_o), 0);
    @(negedge clk_i);
    model(1'b0, 1'b1, 12'hA5C);
    chk("R2 ack on third edge", int'(ack_o), 1);
    // R2 held strobe loads once; R3 bypass leaves busy low
    repeat (10) @(negedge clk_i);
    chk("R2 held strobe no second load", int'(busy_o), 0);
    chk("R3 bypass busy", int'(busy_o), int'(m_fv));
    strobe_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R10 bit order, R4 promotion
    op(1'b1, 1'b0, '0, 4, "R10");
    chk("R10 bit mapping", int'(enc_word_o), 12'hA5C);
    // R4 idle promotion: no load
    op(1'b1, 1'b0, '0, 4, "R4 idle");
    chk("R9 ack held after idle promotions", int'(ack_o), 1);

    // R3 bypass, R5 queue, R7 overwrite, R6 promote
    op(1'b0, 1'b1, 12'h111, 4, "R3");
    chk("R3 ack", int'(ack_o), 1);
    op(1'b0, 1'b1, 12'h222, 4, "R5");
    chk("R5 busy", int'(busy_o), 1);
    chk("R5 ack low", int'(ack_o), 0);
    op(1'b0, 1'b1, 12'h333, 4, "R7");
    op(1'b1, 1'b0, '0, 4, "R6");
    chk("R6 ack", int'(ack_o), 1);
    chk("R6 busy", int'(busy_o), 0);
    chk("R4 rear word out", int'(enc_word_o), 12'h111);
    op(1'b1, 1'b0, '0, 4, "R7 drain");
    chk("R7 last overwrite wins", int'(enc_word_o), 12'h333);

    // R8 same-cycle promotion and strobe
    op(1'b0, 1'b1, 12'h444, 4, "R8 setup");
    op(1'b1, 1'b1, 12'h555, 4, "R8");
    chk("R8 enc gets old rear", int'(enc_word_o), 12'h444);
    chk("R8 strobe bypasses freed rear", int'(busy_o), 0);
    op(1'b0, 1'b1, 12'h666, 4, "R8 fill front");
    op(1'b1, 1'b1, 12'h777, 4, "R8 full");
    chk("R8 full: new word queued", int'(busy_o), 1);
    chk("R8 full: enc", int'(enc_word_o), 12'h555);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit p, s;
      logic [W-1:0] w;
      p = ($urandom % 3) == 0;
      s = ($urandom % 2) == 0;
      w = W'($urandom);
      op(p, s, w, 4 + ($urandom % 3), "rand");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule